// File: doc/BRIEF.md
# TDM Audio Frame Serializer

This block is the transmit half of a controller on a point-to-point, time-division serial audio link. The codec side supplies the bit clock. The block counts that clock down into fixed 256-bit frames and drives a frame-sync line and one serial data line. Each frame starts with a 16-bit tag slot. Twelve 20-bit data slots follow. Every bit of the tag slot says whether one of the data slots carries valid content.

The user side presents four playback PCM channels and a single control-register write port. The write port uses a command slot and a data slot, and each source has its own valid flag. The block samples all of these inputs once per frame, at the frame boundary. It builds the tag slot from the valid flags and forces every untagged slot to zeros. It then shifts the frame out MSB first, one bit per rising bit-clock edge, so the codec can sample on the falling edge. A one-cycle request strobe marks the start of each frame. This tells the user side that the next set of inputs is due before the frame ends.

Top module: `tdm_frame_tx`

## Requirements
- R1: A frame is 256 bit clocks long. `frame_req` is high for exactly one bit clock per frame, the first bit clock of slot 0, so consecutive pulses are 256 bit clocks apart.
- R2: `frame_sync` is high for the 16 bit clocks of slot 0 and low for the other 240 bit clocks of each frame.
- R3: Slot 0 carries the tag word MSB first. Bit 15 is 1 when any data slot is tagged valid. Bits 14 down to 3 are the tags of slots 1 to 12 in that order. Bits 2..0 are always 0.
- R4: Slot 1 is tagged valid when `reg_valid` is 1. It carries `reg_read` in bit 19, `reg_addr` in bits 18..12 and zeros in bits 11..0.
- R5: Slot 2 is tagged valid only when `reg_valid` is 1 and `reg_read` is 0. It then carries `reg_wdata` in bits 19..4 and zeros in bits 3..0.
- R6: PCM channels 0, 1, 2 and 3 occupy slots 3, 4, 6 and 9. Each channel is tagged by its bit of `pcm_valid`, and its 16-bit sample fills bits 19..4 of the slot. Slots 5, 7, 8, 10, 11 and 12 are never tagged.
- R7: Every slot whose tag is 0 is sent as 20 zero bits.
- R8: The inputs are sampled on the rising edge that sends the last bit of a frame, and they define the next frame. Input changes at any other time have no effect on the frame being sent.
- R9: While `rst` is high at a rising edge, `frame_sync`, `ser_data` and `frame_req` go low. After release, the first rising edge loads the inputs and the second rising edge begins slot 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock from the codec; outputs change on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| pcm_valid | input | 4 | Valid flag per playback channel (bit i for channel i) |
| pcm_data | input | 64 | Playback samples, channel i in bits [16*i+15:16*i] |
| reg_valid | input | 1 | A register command is to be sent this frame |
| reg_read | input | 1 | Command is a read (1) or a write (0) |
| reg_addr | input | 7 | Register address |
| reg_wdata | input | 16 | Register write data |
| frame_sync | output | 1 | Frame sync, high during the tag slot |
| ser_data | output | 1 | Serial frame data, MSB first |
| frame_req | output | 1 | One-cycle strobe at frame start requesting the next inputs |

## Verification
All three outputs are registered. The bit carrying frame index n appears one rising edge after the bit counter reaches n, and the inputs latched on the edge that sends bit 255 show up as tag bit 15 on the following edge. After a reset release, slot 0 starts on the second rising edge. The bench samples every output at the falling edge, counts falling edges from release to the first `frame_req`, and then captures the 256 bits that start at that falling edge. It changes the inputs to the next pattern at the start of every frame. A frame that still shows the previous pattern therefore confirms that the inputs are latched only at the boundary.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

  localparam int TAG_W     = 16;
  localparam int SLOT_W    = 20;
  localparam int NUM_DSLOT = 12;
  localparam int NUM_SLOT  = NUM_DSLOT + 1;
  localparam int NUM_CH    = 4;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int PCM_W     = 16;
  localparam int SIDX_W    = $clog2(NUM_SLOT);
  localparam int BIDX_W    = $clog2(SLOT_W);
  localparam int FRAME_LEN = TAG_W + NUM_DSLOT * SLOT_W;
  localparam int GAP_W     = $clog2(FRAME_LEN) + 1;

  typedef logic [SLOT_W-1:0] slot_word_t;

  // slot that carries playback channel ch
  function automatic int chan_slot(input int ch);
    case (ch)
      0:       return 3;
      1:       return 4;
      2:       return 6;
      default: return 9;
    endcase
  endfunction

  function automatic slot_word_t pcm_word(input logic [PCM_W-1:0] s);
    return slot_word_t'(s) << (SLOT_W - PCM_W);
  endfunction

  function automatic slot_word_t cmd_word(input logic rd, input logic [ADDR_W-1:0] a);
    slot_word_t w;
    w = '0;
    w[SLOT_W-1] = rd;
    w[SLOT_W-2 -: ADDR_W] = a;
    return w;
  endfunction

  function automatic slot_word_t data_word(input logic [DATA_W-1:0] d);
    return slot_word_t'(d) << (SLOT_W - DATA_W);
  endfunction

  // tag layout: MSB = any slot valid, then slots 1..NUM_DSLOT, rest zero
  function automatic logic [TAG_W-1:0] tag_pack(input logic [NUM_DSLOT:1] v);
    logic [TAG_W-1:0] t;
    t = '0;
    t[TAG_W-1] = |v;
    for (int s = 1; s <= NUM_DSLOT; s++) t[TAG_W-1-s] = v[s];
    return t;
  endfunction

  // bit position inside the tag word of a data slot's tag
  function automatic logic [BIDX_W-1:0] tag_pos(input logic [SIDX_W-1:0] slot);
    return BIDX_W'(TAG_W - 1) - BIDX_W'(slot);
  endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer
  import tdm_tx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [SIDX_W-1:0] slot_o,
  output logic [BIDX_W-1:0] bit_o,
  output logic              frame_end_o
);

  localparam logic [SIDX_W-1:0] LAST_SLOT = SIDX_W'(NUM_DSLOT);
  localparam logic [BIDX_W-1:0] TAG_MSB   = BIDX_W'(TAG_W - 1);
  localparam logic [BIDX_W-1:0] SLOT_MSB  = BIDX_W'(SLOT_W - 1);

  logic [SIDX_W-1:0] slot_q;
  logic [BIDX_W-1:0] bit_q;
  logic              last_bit;

  assign last_bit = (bit_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= LAST_SLOT;
      bit_q  <= '0;
    end else if (last_bit) begin
      if (slot_q == LAST_SLOT) begin
        slot_q <= '0;
        bit_q  <= TAG_MSB;
      end else begin
        slot_q <= slot_q + 1'b1;
        bit_q  <= SLOT_MSB;
      end
    end else begin
      bit_q <= bit_q - 1'b1;
    end
  end

  assign slot_o      = slot_q;
  assign bit_o       = bit_q;
  assign frame_end_o = last_bit && (slot_q == LAST_SLOT);

  // R1
  tag_bit_range_chk: assert property (@(posedge clk) disable iff (rst)
    (slot_q == '0) |-> (bit_q <= TAG_MSB));

  // R1
  slot_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end_o |=> (slot_q == '0 && bit_q == TAG_MSB));

endmodule

// File: rtl/tdm_frame_builder.sv
module tdm_frame_builder
  import tdm_tx_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               load_i,
  input  logic [NUM_CH-1:0]                  pcm_valid_i,
  input  logic [NUM_CH*PCM_W-1:0]            pcm_data_i,
  input  logic                               reg_valid_i,
  input  logic                               reg_read_i,
  input  logic [ADDR_W-1:0]                  reg_addr_i,
  input  logic [DATA_W-1:0]                  reg_wdata_i,
  output logic [NUM_SLOT-1:0][SLOT_W-1:0]    words_o
);

  logic [NUM_DSLOT:1]                 slot_on;
  slot_word_t                         payload [1:NUM_DSLOT];
  logic [NUM_SLOT-1:0][SLOT_W-1:0]    words_d;
  logic [NUM_SLOT-1:0][SLOT_W-1:0]    words_q;

  always_comb begin
    slot_on = '0;
    for (int s = 1; s <= NUM_DSLOT; s++) payload[s] = '0;
    slot_on[1] = reg_valid_i;
    payload[1] = cmd_word(reg_read_i, reg_addr_i);
    slot_on[2] = reg_valid_i & ~reg_read_i;
    payload[2] = data_word(reg_wdata_i);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      slot_on[chan_slot(ch)] = pcm_valid_i[ch];
      payload[chan_slot(ch)] = pcm_word(pcm_data_i[ch*PCM_W +: PCM_W]);
    end
  end

  assign words_d[0] = SLOT_W'(tag_pack(slot_on));

  generate
    for (genvar s = 1; s <= NUM_DSLOT; s++) begin : g_zero_fill
      assign words_d[s] = slot_on[s] ? payload[s] : '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)         words_q <= '0;
    else if (load_i) words_q <= words_d;
  end

  assign words_o = words_q;

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(words_q));

  // R5
  read_no_data_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && reg_valid_i && reg_read_i) |=> (words_q[2] == '0));

  // R6
  pcm0_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (load_i && pcm_valid_i[0]) |=>
      (words_q[chan_slot(0)][SLOT_W-1 -: PCM_W] == $past(pcm_data_i[PCM_W-1:0])));

endmodule

// File: rtl/tdm_line_driver.sv
module tdm_line_driver
  import tdm_tx_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [SIDX_W-1:0]               slot_i,
  input  logic [BIDX_W-1:0]               bit_i,
  input  logic [NUM_SLOT-1:0][SLOT_W-1:0] words_i,
  output logic                            sync_o,
  output logic                            sdata_o,
  output logic                            frame_req_o
);

  localparam logic [BIDX_W-1:0] TAG_MSB = BIDX_W'(TAG_W - 1);

  logic tag_phase;
  logic frame_start;
  logic cur_bit;
  logic cur_tag_off;

  assign tag_phase   = (slot_i == '0);
  assign frame_start = tag_phase && (bit_i == TAG_MSB);
  assign cur_bit     = words_i[slot_i][bit_i];
  assign cur_tag_off = !tag_phase && !words_i[0][tag_pos(slot_i)];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_o      <= 1'b0;
      sdata_o     <= 1'b0;
      frame_req_o <= 1'b0;
    end else begin
      sync_o      <= tag_phase;
      sdata_o     <= cur_bit;
      frame_req_o <= frame_start;
    end
  end

  logic [BIDX_W:0]  sync_run_q;
  logic [GAP_W-1:0] gap_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_run_q <= '0;
      gap_q      <= '0;
      seen_q     <= 1'b0;
    end else begin
      sync_run_q <= sync_o ? sync_run_q + 1'b1 : '0;
      gap_q      <= frame_req_o ? '0 : gap_q + 1'b1;
      if (frame_req_o) seen_q <= 1'b1;
    end
  end

  // R7
  untagged_zero_chk: assert property (@(posedge clk) disable iff (rst)
    cur_tag_off |=> !sdata_o);

  // R9
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!sync_o && !sdata_o && !frame_req_o));

  // R2
  sync_width_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(sync_o) && !$past(rst)) |-> (sync_run_q == (BIDX_W+1)'(TAG_W)));

  // R1
  frame_period_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_req_o && seen_q) |-> (gap_q == GAP_W'(FRAME_LEN - 1)));

  // R1
  req_in_sync_chk: assert property (@(posedge clk) disable iff (rst)
    frame_req_o |-> sync_o);

endmodule

// File: rtl/tdm_frame_tx.sv
module tdm_frame_tx
  import tdm_tx_pkg::*;
(
  input  logic                    bclk,
  input  logic                    rst,
  input  logic [NUM_CH-1:0]       pcm_valid,
  input  logic [NUM_CH*PCM_W-1:0] pcm_data,
  input  logic                    reg_valid,
  input  logic                    reg_read,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DATA_W-1:0]       reg_wdata,
  output logic                    frame_sync,
  output logic                    ser_data,
  output logic                    frame_req
);

  logic [SIDX_W-1:0]               slot_idx;
  logic [BIDX_W-1:0]               bit_idx;
  logic                            frame_end;
  logic [NUM_SLOT-1:0][SLOT_W-1:0] frame_words;

  tdm_slot_timer u_timer (
    .clk         (bclk),
    .rst         (rst),
    .slot_o      (slot_idx),
    .bit_o       (bit_idx),
    .frame_end_o (frame_end)
  );

  tdm_frame_builder u_builder (
    .clk         (bclk),
    .rst         (rst),
    .load_i      (frame_end),
    .pcm_valid_i (pcm_valid),
    .pcm_data_i  (pcm_data),
    .reg_valid_i (reg_valid),
    .reg_read_i  (reg_read),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .words_o     (frame_words)
  );

  tdm_line_driver u_driver (
    .clk         (bclk),
    .rst         (rst),
    .slot_i      (slot_idx),
    .bit_i       (bit_idx),
    .words_i     (frame_words),
    .sync_o      (frame_sync),
    .sdata_o     (ser_data),
    .frame_req_o (frame_req)
  );

  // R3
  tag_reserved_chk: assert property (@(posedge bclk) disable iff (rst)
    (frame_words[0][TAG_W-1-NUM_DSLOT-1:0] == '0));

endmodule

// File: tb/tdm_frame_tx_bench.sv
module tdm_frame_tx_bench;

  localparam int CLK_P = 10;

  logic        bclk = 1'b0;
  logic        rst  = 1'b1;
  logic [3:0]  pcm_valid;
  logic [63:0] pcm_data;
  logic        reg_valid, reg_read;
  logic [6:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic        frame_sync, ser_data, frame_req;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_P/2) bclk = ~bclk;

  tdm_frame_tx u_tdm_frame_tx (
    .bclk(bclk), .rst(rst), .pcm_valid(pcm_valid), .pcm_data(pcm_data),
    .reg_valid(reg_valid), .reg_read(reg_read), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .frame_sync(frame_sync), .ser_data(ser_data),
    .frame_req(frame_req)
  );

  // ---- stimulus pattern k, computed arithmetically ----
  function automatic logic [15:0] smp(int k, int ch);
    if (k == 64) return 16'hFFFF;
    return 16'((k * 40503 + ch * 4999 + 7) % 65536);
  endfunction
  function automatic logic [3:0] pv(int k);
    return (k == 64) ? 4'hF : 4'(k % 16);
  endfunction
  function automatic logic rv(int k);
    return (k == 64) ? 1'b1 : 1'((k / 16) % 2);
  endfunction
  function automatic logic rd(int k);
    return (k == 64) ? 1'b0 : 1'((k / 32) % 2);
  endfunction
  function automatic logic [6:0] ad(int k);
    return 7'((k * 37 + 3) % 128);
  endfunction
  function automatic logic [15:0] wd(int k);
    return 16'((k * 2654 + 165) % 65536);
  endfunction

  function automatic bit slot_on(int k, int s);
    logic [3:0] v;
    v = pv(k);
    case (s)
      1: return rv(k);
      2: return rv(k) && !rd(k);
      3: return v[0];
      4: return v[1];
      6: return v[2];
      9: return v[3];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [19:0] exp_slot(int k, int s);
    if (!slot_on(k, s)) return 20'h0;
    case (s)
      1: return {rd(k), ad(k), 12'h000};
      2: return {wd(k), 4'h0};
      3: return {smp(k, 0), 4'h0};
      4: return {smp(k, 1), 4'h0};
      6: return {smp(k, 2), 4'h0};
      default: return {smp(k, 3), 4'h0};
    endcase
  endfunction

  function automatic logic [15:0] exp_tag(int k);
    int t;
    t = 0;
    for (int s = 1; s <= 12; s++) if (slot_on(k, s)) t = t + (1 << (15 - s));
    if (t != 0) t = t + 32768;
    return 16'(t);
  endfunction

  task automatic apply(int k);
    pcm_valid = pv(k);
    for (int ch = 0; ch < 4; ch++) pcm_data[ch*16 +: 16] = smp(k, ch);
    reg_valid = rv(k);
    reg_read  = rd(k);
    reg_addr  = ad(k);
    reg_wdata = wd(k);
  endtask

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, expv, $time);
    end
  endtask

  // Capture one frame; called at the falling edge that shows bit 0.
  task automatic capture(int k);
    logic [0:255] bits;
    logic [15:0]  tagw;
    logic [19:0]  w;
    int sync_bad, req_bad;
    bit all_ok;
    sync_bad = 0; req_bad = 0; all_ok = 1;
    for (int idx = 0; idx < 256; idx++) begin
      if (idx > 0) @(negedge bclk);
      if (frame_sync !== (idx < 16)) sync_bad++;
      if (frame_req !== (idx == 0)) req_bad++;
      bits[idx] = ser_data;
    end
    for (int i = 0; i < 16; i++) tagw[15-i] = bits[i];
    chk(tagw === exp_tag(k), "R3 tag word", 32'(tagw), 32'(exp_tag(k)));
    if (tagw !== exp_tag(k)) all_ok = 0;
    for (int s = 1; s <= 12; s++) begin
      for (int j = 0; j < 20; j++) w[19-j] = bits[16 + (s-1)*20 + j];
      if (w !== exp_slot(k, s)) all_ok = 0;
      if (s == 1)
        chk(w === exp_slot(k, s), "R4 command slot", 32'(w), 32'(exp_slot(k, s)));
      else if (s == 2)
        chk(w === exp_slot(k, s), "R5 write data slot", 32'(w), 32'(exp_slot(k, s)));
      else if (s == 3 || s == 4 || s == 6 || s == 9)
        chk(w === exp_slot(k, s), "R6 pcm slot", 32'(w), 32'(exp_slot(k, s)));
      else
        chk(w === 20'h0, "R7 untagged slot zero", 32'(w), 32'h0);
    end
    chk(all_ok, "R8 frame shows inputs latched at prior boundary", 32'(all_ok), 32'h1);
    chk(sync_bad == 0, "R2 sync shape", 32'(sync_bad), 32'h0);
    chk(req_bad == 0, "R1 request strobe position", 32'(req_bad), 32'h0);
  endtask

  task automatic wait_first_req(output int n);
    n = 0;
    do begin
      @(negedge bclk);
      n++;
    end while (!frame_req && n < 600);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int n;
    apply(0);
    // R9: outputs held low during reset
    for (int i = 0; i < 4; i++) begin
      @(negedge bclk);
      chk({frame_sync, ser_data, frame_req} === 3'b000, "R9 reset quiet",
          32'({frame_sync, ser_data, frame_req}), 32'h0);
    end
    rst = 1'b0;
    wait_first_req(n);
    chk(n == 2, "R9 first frame after release", 32'(n), 32'd2);
    // sweep: inputs for frame k+1 change while frame k is being sent
    for (int k = 0; k <= 64; k++) begin
      if (k > 0) begin
        @(negedge bclk);
        chk(frame_req === 1'b1, "R1 frame period 256", 32'(frame_req), 32'h1);
      end
      apply((k == 64) ? 0 : k + 1);
      capture(k);
    end
    // mid-frame reset
    repeat (100) @(negedge bclk);
    rst = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge bclk);
      chk({frame_sync, ser_data, frame_req} === 3'b000, "R9 mid-frame reset quiet",
          32'({frame_sync, ser_data, frame_req}), 32'h0);
    end
    apply(7);
    rst = 1'b0;
    wait_first_req(n);
    chk(n == 2, "R9 restart after reset", 32'(n), 32'd2);
    apply(0);
    capture(7);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule